// File: doc/BRIEF.md
# Carry-Propagate Mask Generator

This block takes a propagate vector and a generate vector, one bit per element of a big integer. It returns the carry that enters every element, all in one operation. Bit i of the result is the carry that element i must add. The vector can therefore act directly as a predicate mask for a vectorised add-with-carry pass. An external carry bit is fed into element 0, and the carry leaving the top element is returned.

The result is defined by the identity ((P | G) + G + carryIn) XOR P, taken at the vector width. The hardware does not use a wide adder for it. It builds the carries with a parallel-prefix network. An optional record request also produces a zero indication: the zero flag is set when no element receives a carry.

The operation is registered once. A request presented with `inValid` appears on the outputs in the following cycle. The outputs then hold until the next request.

Top module: `cprop_top`

## Requirements
- R1: When `inValid` is high, the `carryMask` presented in the next cycle equals ((P | G) + G + carryIn) XOR P, truncated to WIDTH bits. `carryIn` adds one to the sum.
- R2: For inputs with P AND G equal to zero, bit i of `carryMask` equals the ripple carry into element i. That carry starts at `carryIn` for bit 0, and the carry into bit i+1 is G[i] OR (P[i] AND carry into bit i).
- R3: `carryOut` equals the carry out of the most significant bit of the sum (P | G) + G + carryIn.
- R4: `outValid` is high in exactly the cycle after a cycle with `inValid` high, and low otherwise.
- R5: When `inValid` is low, `carryMask`, `carryOut`, `zeroFlag` and `flagsValid` keep their values. `outValid` is excepted and drops per R4.
- R6: When a request has `recordEn` high, `flagsValid` is high together with its result. In that cycle `zeroFlag` is 1 exactly when `carryMask` is all zeros.
- R7: When a request has `recordEn` low, `flagsValid` and `zeroFlag` are both 0 with its result.
- R8: While `rst_n` is low and after reset, before any request, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| propVec | input | WIDTH | Propagate vector P |
| genVec | input | WIDTH | Generate vector G |
| carryIn | input | 1 | Carry into element 0 |
| recordEn | input | 1 | Request the zero flag |
| outValid | output | 1 | Result valid |
| carryMask | output | WIDTH | Carry into every element |
| carryOut | output | 1 | Carry out of the top element |
| zeroFlag | output | 1 | No element receives a carry (record only) |
| flagsValid | output | 1 | zeroFlag is meaningful |

## Verification
The hardest case to reach is a carry that crosses the full width of the vector. This happens when a long run of propagate bits sits above a generate bit or above `carryIn`, so that every prefix level must combine correctly. Random vectors almost never contain such runs. The stimulus therefore adds directed vectors: all-propagate with a carry in, a single generate at bit 0 under all propagates, and a generate only at the top bit. Random disjoint P/G pairs are checked against a ripple model, and unconstrained pairs, which include overlapping bits, are checked against the arithmetic identity.

// File: rtl/cprop_pkg.sv
package cprop_pkg;
  typedef struct packed {
    logic capture;
    logic record;
  } cprop_strobe_t;
endpackage

// File: rtl/cprop_ctrl.sv
module cprop_ctrl
  import cprop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          recordEn,
  output cprop_strobe_t strobe,
  output logic          outValid,
  output logic          flagsValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.record  = inValid & recordEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      flagsValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) flagsValid <= recordEn;
    end
  end
endmodule

// File: rtl/cprop_datapath.sv
module cprop_datapath
  import cprop_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cprop_strobe_t    strobe,
  input  logic [WIDTH-1:0] propVec,
  input  logic [WIDTH-1:0] genVec,
  input  logic             carryIn,
  output logic [WIDTH-1:0] carryMask,
  output logic             carryOut,
  output logic             zeroFlag
);
  localparam int LEVELS = $clog2(WIDTH);

  // Adder operands a=P|G, b=G: per-bit generate a&b = G, propagate a^b = P&~G.
  logic [WIDTH-1:0] grpGen  [0:LEVELS];
  logic [WIDTH-1:0] grpProp [0:LEVELS];

  assign grpGen[0]  = genVec;
  assign grpProp[0] = propVec & ~genVec;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam int SPAN = 1 << lvl;
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b >= SPAN) begin : g_merge
        assign grpGen[lvl+1][b]  = grpGen[lvl][b] | (grpProp[lvl][b] & grpGen[lvl][b-SPAN]);
        assign grpProp[lvl+1][b] = grpProp[lvl][b] & grpProp[lvl][b-SPAN];
      end else begin : g_pass
        assign grpGen[lvl+1][b]  = grpGen[lvl][b];
        assign grpProp[lvl+1][b] = grpProp[lvl][b];
      end
    end
  end

  // carryVec[i] = carry into bit i; carryVec[WIDTH] = carry out.
  logic [WIDTH:0]   carryVec;
  logic [WIDTH-1:0] nextMask;

  assign carryVec[0] = carryIn;
  for (genvar b = 0; b < WIDTH; b++) begin : g_carry
    assign carryVec[b+1] = grpGen[LEVELS][b] | (grpProp[LEVELS][b] & carryIn);
  end

  // sum_i ^ P_i = c_i ^ (P_i & G_i)
  assign nextMask = carryVec[WIDTH-1:0] ^ (propVec & genVec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carryMask <= '0;
      carryOut  <= 1'b0;
      zeroFlag  <= 1'b0;
    end else if (strobe.capture) begin
      carryMask <= nextMask;
      carryOut  <= carryVec[WIDTH];
      zeroFlag  <= strobe.record & ~(|nextMask);
    end
  end
endmodule

// File: rtl/cprop_top.sv
module cprop_top
  import cprop_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [WIDTH-1:0] propVec,
  input  logic [WIDTH-1:0] genVec,
  input  logic             carryIn,
  input  logic             recordEn,
  output logic             outValid,
  output logic [WIDTH-1:0] carryMask,
  output logic             carryOut,
  output logic             zeroFlag,
  output logic             flagsValid
);
  cprop_strobe_t strobe;

  cprop_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .recordEn(recordEn),
    .strobe(strobe), .outValid(outValid), .flagsValid(flagsValid)
  );

  cprop_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .propVec(propVec),
    .genVec(genVec), .carryIn(carryIn), .carryMask(carryMask),
    .carryOut(carryOut), .zeroFlag(zeroFlag)
  );
endmodule

// File: rtl/cprop_checker.sv
module cprop_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [WIDTH-1:0] propVec,
  input logic [WIDTH-1:0] genVec,
  input logic             carryIn,
  input logic             recordEn,
  input logic             outValid,
  input logic [WIDTH-1:0] carryMask,
  input logic             carryOut,
  input logic             zeroFlag,
  input logic             flagsValid
);
  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, propVec | genVec} + {1'b0, genVec} + {{WIDTH{1'b0}}, carryIn};

  // R1
  mask_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> carryMask == $past(refSum[WIDTH-1:0] ^ propVec));
  // R3
  carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> carryOut == $past(refSum[WIDTH]));
  // R4
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid && $stable(carryMask) && $stable(carryOut) && $stable(zeroFlag));
  // R6
  record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && recordEn) |=> flagsValid && (zeroFlag == (carryMask == '0)));
  // R7
  no_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !recordEn) |=> !flagsValid && !zeroFlag);
endmodule

bind cprop_top cprop_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_cprop_top.sv
module tb_cprop_top;
  localparam int W = 64;
  logic clk = 0, rst_n = 0, inValid = 0, carryIn = 0, recordEn = 0;
  logic [W-1:0] propVec = '0, genVec = '0;
  logic outValid, carryOut, zeroFlag, flagsValid;
  logic [W-1:0] carryMask;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cprop_top #(.WIDTH(W)) dut (.*);

  function automatic logic [W:0] identRef(logic [W-1:0] p, logic [W-1:0] g, logic c);
    logic [W:0] s;
    s = {1'b0, p | g} + {1'b0, g} + {{W{1'b0}}, c};
    return {s[W], s[W-1:0] ^ p};
  endfunction

  function automatic logic [W:0] rippleRef(logic [W-1:0] p, logic [W-1:0] g, logic c);
    logic [W-1:0] m;
    logic cy;
    cy = c;
    for (int i = 0; i < W; i++) begin
      m[i] = cy;
      cy = g[i] | (p[i] & cy);
    end
    return {cy, m};
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] p, logic [W-1:0] g, logic c, logic rec, bit ripple);
    logic [W:0] e;
    @(negedge clk);
    propVec = p; genVec = g; carryIn = c; recordEn = rec; inValid = 1;
    @(negedge clk);
    inValid = 0;
    e = ripple ? rippleRef(p, g, c) : identRef(p, g, c);
    check(ripple ? "R2" : "R1", {1'b0, carryMask}, {1'b0, e[W-1:0]});
    check("R3", {{W{1'b0}}, carryOut}, {{W{1'b0}}, e[W]});
    check("R4", {{W{1'b0}}, outValid}, {{W{1'b0}}, 1'b1});
    if (rec)
      check("R6", {{(W-1){1'b0}}, flagsValid, zeroFlag}, {{(W-1){1'b0}}, 1'b1, e[W-1:0] == '0});
    else
      check("R7", {{(W-1){1'b0}}, flagsValid, zeroFlag}, '0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p, g, holdMask;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R8", {carryMask, carryOut}, '0);
    check("R8", {{(W-2){1'b0}}, outValid, zeroFlag, flagsValid}, '0);
    rst_n = 1;
    @(negedge clk);
    check("R8", {carryMask, outValid}, '0);
    // directed corners
    apply('0, '0, 1'b0, 1'b1, 1);
    apply('1, '0, 1'b1, 1'b1, 1);
    apply('1, '0, 1'b0, 1'b1, 1);
    apply({{(W-1){1'b1}}, 1'b0}, 64'h1, 1'b0, 1'b0, 1);
    apply('0, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 1);
    apply('0, '1, 1'b1, 1'b0, 0);
    apply('1, '1, 1'b0, 1'b1, 0);
    // R5: outputs hold with inValid low
    holdMask = carryMask;
    @(negedge clk);
    propVec = '1; genVec = 64'h5; carryIn = 1; recordEn = 0;
    repeat (3) @(negedge clk);
    check("R5", {1'b0, carryMask}, {1'b0, holdMask});
    check("R5", {{(W-2){1'b0}}, outValid, flagsValid}, {{(W-2){1'b0}}, 1'b0, 1'b1});
    // random disjoint vs ripple
    for (int n = 0; n < 300; n++) begin
      p = {$urandom, $urandom};
      g = {$urandom, $urandom} & {$urandom, $urandom} & ~p;
      apply(p, g, 1'($urandom), 1'($urandom), 1);
    end
    // random unconstrained vs identity
    for (int n = 0; n < 200; n++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom), 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule